// File: doc/BRIEF.md
# Paged Scratchpad Address Unit

This unit sits between an 8-bit load-store core and its data memory. For each load, store or peripheral access it builds the byte address. It takes an in-page offset and places page-pointer bytes above it. The offset is either a 5-bit field from the instruction, zero-extended (direct mode), or a full byte from a general register (indirect mode). A parameter picks the memory model: small (8-bit address, no page pointer), medium (16-bit address, one pointer byte) or large (32-bit address, three pointer bytes).

Once the address is formed, the unit runs the transfer. A scratchpad built inside the block returns read data on the cycle after the address is presented. A scratchpad outside the block is reached through a request/acknowledge handshake, which costs at least one extra cycle. Peripheral accesses always use the handshake, on their own request line. A `busy` output tells the core to stall, and a one-cycle `done` pulse ends each access.

The controller has three states. In `ST_IDLE` it waits for `start`. On `start` it goes to `ST_BUS` for a peripheral access or an external-scratchpad access, and to `ST_DONE` for an internal-scratchpad access. `ST_BUS` stays put until `bus_ack` is sampled and then goes to `ST_DONE`. `ST_DONE` always returns to `ST_IDLE`.

Top module: `spad_agu`

## Requirements
- R1: With the small model, `bus_addr` is 8 bits wide and equals the in-page offset; `page_ptr` has no effect.
- R2: With the medium model, `bus_addr` is 16 bits: `page_ptr[7:0]` forms bits 15:8 and the offset forms bits 7:0.
- R3: With the large model, `bus_addr` is 32 bits. `page_ptr[7:0]` forms bits 15:8, `page_ptr[15:8]` forms bits 23:16, `page_ptr[23:16]` forms bits 31:24, and the offset forms bits 7:0.
- R4: When `direct`=1 the offset is `{3'b000, imm_off}` and `reg_off` has no effect. When `direct`=0 the offset is `reg_off` and `imm_off` has no effect.
- R5: With an internal scratchpad, a non-peripheral access raises no request. `done` is high in the cycle right after the clock edge that samples `start`. A read returns the byte last written at the same index, where the index is the low address bits (the low 8 bits for a 256-byte store).
- R6: With an external scratchpad, `sp_req` rises in the cycle after `start` is accepted. `bus_addr`, `bus_wdata` and `bus_we` stay stable until `bus_ack` is sampled high. `done` follows in the next cycle, and `rdata` then carries the `bus_rdata` captured with the acknowledge.
- R7: A peripheral access (`is_periph`=1) forms its address the same way but always uses the handshake on `io_req`, never `sp_req`, whatever the scratchpad type.
- R8: `done` is a single-cycle pulse. `busy` is high from the cycle after an accepted `start` through the `done` cycle.
- R9: A `start` that arrives while `busy` is high is ignored. It produces no access and no `done`, and it does not change `bus_addr`.
- R10: During and right after reset, `busy`, `done`, `sp_req` and `io_req` are all low.
- R11: `sp_req` and `io_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an access (accepted only when idle) |
| is_periph | input | 1 | Access targets peripheral space |
| is_write | input | 1 | 1 = store, 0 = load |
| direct | input | 1 | 1 = offset from instruction field, 0 = from register |
| imm_off | input | 5 | Instruction offset field |
| reg_off | input | 8 | Register-supplied offset |
| page_ptr | input | 24 | Page-pointer bytes, least significant first |
| wdata | input | 8 | Store data |
| busy | output | 1 | Stall request to the core |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Load result, valid with `done` |
| bus_addr | output | AW (8/16/32) | Latched access address |
| bus_wdata | output | 8 | Latched store data |
| bus_we | output | 1 | Latched write enable |
| sp_req | output | 1 | External scratchpad request |
| io_req | output | 1 | Peripheral request |
| bus_ack | input | 1 | Acknowledge for either request |
| bus_rdata | input | 8 | Read data returned with the acknowledge |

## Verification
Two things can land in the same cycle. A fresh `start` can arrive exactly when an acknowledge ends a handshake, or exactly when an internal access is in its `done` cycle. The bench provokes both with one access. It uses a zero-latency responder and raises a second `start` with a different offset in the cycle after the first was accepted. This is the acknowledge cycle for the external instance and the `done` cycle for the internal ones. The scoreboard then expects exactly one completion, carrying the first address, with an empty queue afterwards. Any extra `done`, or any address taken from the stray request, shows up as a mismatch.

// File: rtl/spad_pkg.sv
package spad_pkg;

    localparam int MODEL_SMALL  = 0;
    localparam int MODEL_MEDIUM = 1;
    localparam int MODEL_LARGE  = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_DONE = 2'd2
    } spad_state_e;

    function automatic int spad_addr_width(input int model);
        if (model == MODEL_SMALL)  return 8;
        if (model == MODEL_MEDIUM) return 16;
        return 32;
    endfunction

endpackage

// File: rtl/spad_addr_gen.sv
module spad_addr_gen
    import spad_pkg::*;
#(
    parameter int MODEL = MODEL_LARGE,
    localparam int AW   = spad_addr_width(MODEL)
) (
    input  logic          direct,
    input  logic [4:0]    imm_off,
    input  logic [7:0]    reg_off,
    input  logic [23:0]   page_ptr,
    output logic [AW-1:0] addr
);

    logic [7:0] offset;

    assign offset = direct ? {3'b000, imm_off} : reg_off;

    generate
        if (MODEL == MODEL_SMALL) begin : g_small
            logic unused_pp;
            assign unused_pp = ^page_ptr;
            assign addr      = offset;
        end else if (MODEL == MODEL_MEDIUM) begin : g_medium
            logic unused_pp;
            assign unused_pp = ^page_ptr[23:8];
            assign addr      = {page_ptr[7:0], offset};
        end else begin : g_large
            assign addr = {page_ptr, offset};
        end
    endgenerate

endmodule

// File: rtl/spad_ram.sv
module spad_ram #(
    parameter int DEPTH = 256,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[idx] <= wdata;
            else    rdata    <= mem[idx];
        end
    end

endmodule

// File: rtl/spad_ctrl.sv
module spad_ctrl
    import spad_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic go_bus,
    input  logic bus_ack,
    output logic accept,
    output logic busy,
    output logic done,
    output logic bus_active,
    output logic capture
);

    spad_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)   state_d = go_bus ? ST_BUS : ST_DONE;
            ST_BUS:  if (bus_ack) state_d = ST_DONE;
            ST_DONE:              state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept     = 1'b0;
        busy       = 1'b1;
        done       = 1'b0;
        bus_active = 1'b0;
        capture    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            ST_BUS: begin
                bus_active = 1'b1;
                capture    = bus_ack;
            end
            ST_DONE: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/spad_agu.sv
module spad_agu
    import spad_pkg::*;
#(
    parameter int MODEL       = MODEL_LARGE,
    parameter bit SP_EXTERNAL = 1'b0,
    parameter int RAM_DEPTH   = 256,
    localparam int AW         = spad_addr_width(MODEL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_periph,
    input  logic          is_write,
    input  logic          direct,
    input  logic [4:0]    imm_off,
    input  logic [7:0]    reg_off,
    input  logic [23:0]   page_ptr,
    input  logic [7:0]    wdata,
    output logic          busy,
    output logic          done,
    output logic [7:0]    rdata,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    output logic          bus_we,
    output logic          sp_req,
    output logic          io_req,
    input  logic          bus_ack,
    input  logic [7:0]    bus_rdata
);

    localparam int IW = $clog2(RAM_DEPTH);

    logic [AW-1:0] form_addr;
    logic          go_bus, accept, bus_active, capture;
    logic          periph_q, int_q;
    logic [7:0]    bus_rdata_q, ram_rdata;

    assign go_bus = is_periph | SP_EXTERNAL;

    spad_addr_gen #(.MODEL(MODEL)) i_addr_gen (
        .direct  (direct),
        .imm_off (imm_off),
        .reg_off (reg_off),
        .page_ptr(page_ptr),
        .addr    (form_addr)
    );

    spad_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .go_bus    (go_bus),
        .bus_ack   (bus_ack),
        .accept    (accept),
        .busy      (busy),
        .done      (done),
        .bus_active(bus_active),
        .capture   (capture)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr    <= '0;
            bus_wdata   <= '0;
            bus_we      <= 1'b0;
            periph_q    <= 1'b0;
            int_q       <= 1'b0;
            bus_rdata_q <= '0;
        end else begin
            if (accept) begin
                bus_addr  <= form_addr;
                bus_wdata <= wdata;
                bus_we    <= is_write;
                periph_q  <= is_periph;
                int_q     <= ~go_bus;
            end
            if (capture) bus_rdata_q <= bus_rdata;
        end
    end

    assign sp_req = bus_active & ~periph_q;
    assign io_req = bus_active &  periph_q;
    assign rdata  = int_q ? ram_rdata : bus_rdata_q;

    generate
        if (!SP_EXTERNAL) begin : g_int_ram
            spad_ram #(.DEPTH(RAM_DEPTH)) i_ram (
                .clk  (clk),
                .en   (accept & ~go_bus),
                .we   (is_write),
                .idx  (form_addr[IW-1:0]),
                .wdata(wdata),
                .rdata(ram_rdata)
            );
        end else begin : g_ext_ram
            assign ram_rdata = '0;
        end
    endgenerate

endmodule

// File: rtl/spad_agu_chk.sv
module spad_agu_chk #(
    parameter int AW          = 32,
    parameter bit SP_EXTERNAL = 1'b0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          sp_req,
    input logic          io_req,
    input logic          bus_ack,
    input logic [AW-1:0] bus_addr,
    input logic [7:0]    bus_wdata,
    input logic          bus_we
);

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sp_req && io_req)); // R11

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((sp_req || io_req) && !bus_ack) |=> ((sp_req || io_req) && $stable(sp_req)
            && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we))); // R6

    AST_ACK_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        ((sp_req || io_req) && bus_ack) |=> (done && !sp_req && !io_req)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R8

    AST_BUSY_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(bus_addr)); // R9

    generate
        if (!SP_EXTERNAL) begin : g_int
            AST_INT_NO_SPREQ: assert property (@(posedge clk) disable iff (!rst_n)
                !sp_req); // R5
        end
    endgenerate

endmodule

bind spad_agu spad_agu_chk #(.AW(AW), .SP_EXTERNAL(SP_EXTERNAL)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .sp_req   (sp_req),
    .io_req   (io_req),
    .bus_ack  (bus_ack),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_we   (bus_we)
);

// File: tb/test_spad_agu.sv
`timescale 1ns/1ps

module spad_resp (
    input  logic       clk,
    input  logic       req_sp,
    input  logic       req_io,
    input  logic [7:0] addr_lo,
    input  logic       we,
    input  logic [7:0] wdata,
    input  int         lat,
    output logic       ack,
    output logic [7:0] rdata
);
    logic [7:0] mem [256];
    int cnt;

    initial begin
        ack = 1'b0;
        rdata = 8'h00;
        cnt = 0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    end

    always @(negedge clk) begin
        if (req_sp || req_io) begin
            if (cnt == lat) begin
                ack   <= 1'b1;
                rdata <= req_io ? (addr_lo ^ 8'h5A) : mem[addr_lo];
                if (req_sp && we) mem[addr_lo] <= wdata;
                cnt   <= cnt + 1;
            end else if (cnt < lat) begin
                cnt <= cnt + 1;
            end
        end else begin
            ack <= 1'b0;
            cnt <= 0;
        end
    end
endmodule

module test_spad_agu;

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  kind;   // 0 internal, 1 scratchpad bus, 2 peripheral
        logic        rd;
        logic [7:0]  data;
        logic [31:0] lat;
        logic [31:0] issue;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        start = 1'b0, is_periph = 1'b0, is_write = 1'b0, direct = 1'b0;
    logic [4:0]  imm_off = '0;
    logic [7:0]  reg_off = '0, wdata = '0;
    logic [23:0] page_ptr = '0;
    int          lat = 0;
    int unsigned cyc = 0;
    int          n_checks = 0, n_fail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // instance 0: large, internal; 1: medium, external; 2: small, internal
    logic [2:0]  busy_v, done_v, sp_v, io_v, ack_v, we_v;
    logic [7:0]  rdata_v [3];
    logic [7:0]  brd_v [3];
    logic [7:0]  bwd_v [3];
    logic [31:0] addr_v [3];
    logic [31:0] a_l;
    logic [15:0] a_m;
    logic [7:0]  a_s;

    spad_agu #(.MODEL(2), .SP_EXTERNAL(1'b0)) i_spad_agu (
        .clk(clk), .rst_n(rst_n), .start(start), .is_periph(is_periph), .is_write(is_write),
        .direct(direct), .imm_off(imm_off), .reg_off(reg_off), .page_ptr(page_ptr), .wdata(wdata),
        .busy(busy_v[0]), .done(done_v[0]), .rdata(rdata_v[0]), .bus_addr(a_l),
        .bus_wdata(bwd_v[0]), .bus_we(we_v[0]), .sp_req(sp_v[0]), .io_req(io_v[0]),
        .bus_ack(ack_v[0]), .bus_rdata(brd_v[0]));

    spad_agu #(.MODEL(1), .SP_EXTERNAL(1'b1)) i_spad_agu_med (
        .clk(clk), .rst_n(rst_n), .start(start), .is_periph(is_periph), .is_write(is_write),
        .direct(direct), .imm_off(imm_off), .reg_off(reg_off), .page_ptr(page_ptr), .wdata(wdata),
        .busy(busy_v[1]), .done(done_v[1]), .rdata(rdata_v[1]), .bus_addr(a_m),
        .bus_wdata(bwd_v[1]), .bus_we(we_v[1]), .sp_req(sp_v[1]), .io_req(io_v[1]),
        .bus_ack(ack_v[1]), .bus_rdata(brd_v[1]));

    spad_agu #(.MODEL(0), .SP_EXTERNAL(1'b0)) i_spad_agu_sml (
        .clk(clk), .rst_n(rst_n), .start(start), .is_periph(is_periph), .is_write(is_write),
        .direct(direct), .imm_off(imm_off), .reg_off(reg_off), .page_ptr(page_ptr), .wdata(wdata),
        .busy(busy_v[2]), .done(done_v[2]), .rdata(rdata_v[2]), .bus_addr(a_s),
        .bus_wdata(bwd_v[2]), .bus_we(we_v[2]), .sp_req(sp_v[2]), .io_req(io_v[2]),
        .bus_ack(ack_v[2]), .bus_rdata(brd_v[2]));

    assign addr_v[0] = a_l;
    assign addr_v[1] = {16'h0000, a_m};
    assign addr_v[2] = {24'h000000, a_s};

    for (genvar g = 0; g < 3; g++) begin : g_resp
        spad_resp i_resp (
            .clk(clk), .req_sp(sp_v[g]), .req_io(io_v[g]), .addr_lo(addr_v[g][7:0]),
            .we(we_v[g]), .wdata(bwd_v[g]), .lat(lat), .ack(ack_v[g]), .rdata(brd_v[g]));
    end

    exp_t q0[$], q1[$], q2[$];
    logic [7:0] refm [256];
    logic [2:0] saw_sp = '0, saw_io = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic string addr_tag(input int i);
        if (i == 0) return "R3/R4 large address";
        if (i == 1) return "R2/R4 medium address";
        return "R1/R4 small address";
    endfunction

    function automatic string kind_tag(input logic [1:0] k);
        if (k == 2'd2) return "R7 peripheral";
        if (k == 2'd1) return "R6 external";
        return "R5 internal";
    endfunction

    // monitor: pops expectations as completions appear
    always @(negedge clk) begin
        for (int i = 0; i < 3; i++) begin
            exp_t e;
            logic got;
            got = 1'b0;
            e = '0;
            if (sp_v[i]) saw_sp[i] = 1'b1;
            if (io_v[i]) saw_io[i] = 1'b1;
            if (done_v[i]) begin
                case (i)
                    0: if (q0.size() > 0) begin e = q0.pop_front(); got = 1'b1; end
                    1: if (q1.size() > 0) begin e = q1.pop_front(); got = 1'b1; end
                    default: if (q2.size() > 0) begin e = q2.pop_front(); got = 1'b1; end
                endcase
                if (!got) begin
                    chk("R9 unexpected completion", 32'd1, 32'd0);
                end else begin
                    chk(addr_tag(i), addr_v[i], e.addr);
                    chk({kind_tag(e.kind), " latency R8"}, cyc - e.issue, e.lat);
                    chk({kind_tag(e.kind), " request lines R11"}, {30'd0, saw_io[i], saw_sp[i]},
                        (e.kind == 2'd2) ? 32'd2 : (e.kind == 2'd1) ? 32'd1 : 32'd0);
                    if (e.rd) chk({kind_tag(e.kind), " read data"}, {24'd0, rdata_v[i]}, {24'd0, e.data});
                end
                saw_sp[i] = 1'b0;
                saw_io[i] = 1'b0;
            end
        end
    end

    task automatic push_exp(input int i, input logic [31:0] a, input logic per, input logic we,
                            input logic [7:0] off, input int lt, input int unsigned iss);
        exp_t e;
        logic ext;
        ext    = (i == 1);
        e.addr = a;
        e.kind = per ? 2'd2 : (ext ? 2'd1 : 2'd0);
        e.rd   = ~we;
        e.data = per ? (off ^ 8'h5A) : refm[off];
        e.lat  = (e.kind == 2'd0) ? 32'd1 : 32'(lt + 2);
        e.issue = iss;
        case (i)
            0: q0.push_back(e);
            1: q1.push_back(e);
            default: q2.push_back(e);
        endcase
    endtask

    // driver: one access to all three instances; optional stray start one cycle later
    task automatic access(input logic per, input logic we, input logic dir, input logic [4:0] imm,
                          input logic [7:0] roff, input logic [23:0] pp, input logic [7:0] wd,
                          input int lt, input logic stray);
        logic [7:0] off;
        @(negedge clk);
        is_periph = per; is_write = we; direct = dir; imm_off = imm;
        reg_off = roff; page_ptr = pp; wdata = wd; lat = lt; start = 1'b1;
        off = dir ? {3'b000, imm} : roff;
        push_exp(0, {pp, off}, per, we, off, lt, cyc);
        push_exp(1, {16'h0000, pp[7:0], off}, per, we, off, lt, cyc);
        push_exp(2, {24'h000000, off}, per, we, off, lt, cyc);
        if (we && !per) refm[off] = wd;
        @(negedge clk);
        if (stray) begin
            // R9: coincides with internal done and external acknowledge
            imm_off = imm ^ 5'h1F; reg_off = roff ^ 8'hFF; page_ptr = ~pp; is_write = ~we;
            @(negedge clk);
        end
        start = 1'b0;
        while (|busy_v) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) refm[i] = 8'h00;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3; i++)
            chk("R10 reset outputs", {28'd0, busy_v[i], done_v[i], sp_v[i], io_v[i]}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 3; i++)
            chk("R10 after reset", {28'd0, busy_v[i], done_v[i], sp_v[i], io_v[i]}, 32'd0);

        // direct write then read (R4, R5, R6)
        access(1'b0, 1'b1, 1'b1, 5'd5,  8'h99, 24'h030201, 8'h11, 1, 1'b0);
        access(1'b0, 1'b0, 1'b1, 5'd5,  8'h00, 24'h030201, 8'h00, 1, 1'b0);
        // indirect write then read across page pointers (R1, R2, R3)
        access(1'b0, 1'b1, 1'b0, 5'd7,  8'hC3, 24'hA1B2C3, 8'h77, 2, 1'b0);
        access(1'b0, 1'b0, 1'b0, 5'd0,  8'hC3, 24'h5E6F70, 8'h00, 2, 1'b0);
        // top of direct window equals register offset 0x1F
        access(1'b0, 1'b1, 1'b1, 5'd31, 8'h00, 24'h000102, 8'hEE, 0, 1'b0);
        access(1'b0, 1'b0, 1'b0, 5'd3,  8'h1F, 24'h0A0B0C, 8'h00, 0, 1'b0);
        // R4: register offset ignored in direct mode
        access(1'b0, 1'b1, 1'b1, 5'd2,  8'hFF, 24'h123456, 8'h3C, 1, 1'b0);
        access(1'b0, 1'b0, 1'b1, 5'd2,  8'hFF, 24'h654321, 8'h00, 1, 1'b0);
        // R7: peripheral read and write
        access(1'b1, 1'b0, 1'b0, 5'd0,  8'h40, 24'h00FF00, 8'h00, 3, 1'b0);
        access(1'b1, 1'b1, 1'b1, 5'd9,  8'h00, 24'hFEDCBA, 8'h5F, 0, 1'b0);
        // R9: stray start in the done / acknowledge cycle
        access(1'b0, 1'b0, 1'b0, 5'd0,  8'hC3, 24'h0F0E0D, 8'h00, 0, 1'b1);
        // R6: long handshake
        access(1'b0, 1'b0, 1'b0, 5'd0,  8'h02, 24'h777777, 8'h00, 6, 1'b0);

        chk("R9 no pending or extra completions", q0.size() + q1.size() + q2.size(), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule